// File: doc/BRIEF.md
# Alarm Channel Event Latch and Interrupt Gate

This block turns the live status lines of a far-end alarm and control channel controller into sticky event flags a host can poll or take an interrupt on. Five sources are watched. Three flags record that a status line went active: transmit idle, receive codeword seen and receive idle. One records that the receive FIFO stopped being empty. One records that an incoming codeword was dropped because the FIFO was full. Each flag stays set until the host clears it by writing a 1 to its position, and it sets again only on a new edge of its source.

A small register port gives the host access to three registers: the flag register, a per-flag enable register and a single group enable bit. The interrupt output is registered. It is high while any flag is set and has its enable set, and the group enable is set. Codeword framing, the FIFO storage and the line interface sit outside this block.

Top module: `feac_evt_irq`

## Requirements
- R1: Flag bit 0 sets on a low-to-high transition of `tx_idle_i`. Holding the input high after the host has cleared the flag does not set it again. A new high-going transition does.
- R2: Flag bit 1 sets on a low-to-high transition of `rx_cw_det_i`.
- R3: Flag bit 2 sets on a low-to-high transition of `rx_idle_i`.
- R4: Flag bit 3 sets when `rx_fifo_empty_i` goes from 1 to 0. After reset, the input must first be sampled at 1. An input held at 0 out of reset never sets the flag.
- R5: Flag bit 4 sets in any cycle in which `rx_fifo_ovf_i` is 1 at a rising clock edge.
- R6: Writing the flag register (address 0) clears exactly those flags whose write-data bit is 1. Write-data bits that are 0 leave their flags unchanged, and bits 7:5 have no effect.
- R7: If a flag's set event and a host clear of that flag fall in the same cycle, the flag ends up set.
- R8: `irq_o` is the registered OR over all flags that have their enable bit set (address 1, bits 4:0), qualified by the group enable (address 2, bit 0). It follows a change of flags or enables one clock later.
- R9: Register bits 7:5 of every address, all bits of address 3, and bits 7:1 of address 2 read as 0 and ignore writes. The enable register reads back bits 4:0 as written.
- R10: After reset, all flags, enables and the group enable are 0, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_idle_i | input | 1 | Live transmit-idle status |
| rx_cw_det_i | input | 1 | Live receive-codeword-detected status |
| rx_idle_i | input | 1 | Live receive-idle status |
| rx_fifo_empty_i | input | 1 | Live receive FIFO empty status |
| rx_fifo_ovf_i | input | 1 | One-cycle pulse: codeword dropped on a full FIFO |
| reg_addr_i | input | 2 | Register select: 0 flags, 1 enables, 2 group enable, 3 reserved |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt request, active high, registered |

## Verification
Two things can land on the same flag in one clock: a source event and a host write-1-to-clear. The bench provokes this by pulsing the overflow input and raising transmit idle in the same cycle as a clear of bits 4 and 0. It then reads the flags back and expects both still set. A second pairing sets a flag while the group enable is being changed. This shows the interrupt output moving only on the edge after the register update. Every combination of the 32 flag patterns, 32 enable masks and both group settings is then compared against an arithmetic prediction.

// File: rtl/feac_irq_pkg.sv
package feac_irq_pkg;

   localparam int NSRC = 5;

   typedef enum logic [1:0] {
      SEL_FLAGS = 2'd0,
      SEL_ENA   = 2'd1,
      SEL_GRP   = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      DET_RISE  = 2'd0,
      DET_FALL  = 2'd1,
      DET_LEVEL = 2'd2
   } det_mode_e;

endpackage

// File: rtl/feac_evt_detect.sv
module feac_evt_detect
   import feac_irq_pkg::*;
#(
   parameter det_mode_e MODE    = DET_RISE,
   parameter logic      ARM_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic live_i,
   output logic evt_o
);

   generate
      if (MODE == DET_LEVEL) begin : g_level
         logic unused_clkrst;
         assign unused_clkrst = clk ^ rst_n;
         assign evt_o = live_i;
      end else begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= ARM_LVL;
            else        prev_q <= live_i;
         end
         if (MODE == DET_FALL) begin : g_fall
            assign evt_o = prev_q & ~live_i;
         end else begin : g_rise
            assign evt_o = live_i & ~prev_q;
         end
      end
   endgenerate

endmodule

// File: rtl/feac_sticky_w1c.sv
module feac_sticky_w1c #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] q_q;

   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q_q[b] <= 1'b0;
         else if (set_i[b])  q_q[b] <= 1'b1;
         else if (clr_i[b])  q_q[b] <= 1'b0;
      end
   end

   assign q_o = q_q;

endmodule

// File: rtl/feac_irq_merge.sv
module feac_irq_merge #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] flags_i,
   input  logic [W-1:0] ena_i,
   input  logic         grp_i,
   output logic         irq_o
);

   logic [W-1:0] hit;
   logic         irq_q;

   assign hit = flags_i & ena_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= grp_i & (|hit);
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/feac_evt_irq.sv
module feac_evt_irq
   import feac_irq_pkg::*;
#(
   parameter int              DATA_W     = 8,
   parameter int              ADDR_W     = 2,
   parameter logic [NSRC-1:0] FALL_MASK  = 5'b01000,
   parameter logic [NSRC-1:0] LEVEL_MASK = 5'b10000,
   parameter logic [NSRC-1:0] PREV_RST   = 5'b00000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_idle_i,
   input  logic              rx_cw_det_i,
   input  logic              rx_idle_i,
   input  logic              rx_fifo_empty_i,
   input  logic              rx_fifo_ovf_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);

   localparam int RSV_W = DATA_W - NSRC;

   // elaboration-time parameter checks
   if (DATA_W <= NSRC) begin : g_bad_dw
      $error("DATA_W must exceed the source count");
   end
   if (ADDR_W < 2) begin : g_bad_aw
      $error("ADDR_W must be at least 2");
   end
   if ((FALL_MASK & LEVEL_MASK) != '0) begin : g_bad_mask
      $error("a source cannot be both falling-edge and level");
   end

   logic [NSRC-1:0] live;
   logic [NSRC-1:0] evt;
   logic [NSRC-1:0] clr_mask;
   logic [NSRC-1:0] lat_q;
   logic [NSRC-1:0] en_q;
   logic            grp_q;
   logic            page_hit;
   reg_sel_e        sel;
   logic            wr_hit;

   assign live = {rx_fifo_ovf_i, rx_fifo_empty_i, rx_idle_i, rx_cw_det_i, tx_idle_i};

   for (genvar b = 0; b < NSRC; b++) begin : g_src
      localparam det_mode_e M = LEVEL_MASK[b] ? DET_LEVEL :
                                (FALL_MASK[b] ? DET_FALL : DET_RISE);
      feac_evt_detect #(
         .MODE    (M),
         .ARM_LVL (PREV_RST[b])
      ) u_det (
         .clk    (clk),
         .rst_n  (rst_n),
         .live_i (live[b]),
         .evt_o  (evt[b])
      );
   end

   if (ADDR_W > 2) begin : g_page
      assign page_hit = ~|reg_addr_i[ADDR_W-1:2];
   end else begin : g_nopage
      assign page_hit = 1'b1;
   end

   assign sel    = reg_sel_e'(reg_addr_i[1:0]);
   assign wr_hit = reg_wr_i & page_hit;

   assign clr_mask = (wr_hit && sel == SEL_FLAGS) ? reg_wdata_i[NSRC-1:0] : '0;

   feac_sticky_w1c #(.W(NSRC)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt),
      .clr_i (clr_mask),
      .q_o   (lat_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         grp_q <= 1'b0;
      end else if (wr_hit) begin
         if (sel == SEL_ENA) en_q  <= reg_wdata_i[NSRC-1:0];
         if (sel == SEL_GRP) grp_q <= reg_wdata_i[0];
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata_i[DATA_W-1:NSRC];

   always_comb begin
      reg_rdata_o = '0;
      if (page_hit) begin
         unique case (sel)
            SEL_FLAGS: reg_rdata_o = {{RSV_W{1'b0}}, lat_q};
            SEL_ENA:   reg_rdata_o = {{RSV_W{1'b0}}, en_q};
            SEL_GRP:   reg_rdata_o = {{(DATA_W-1){1'b0}}, grp_q};
            default:   reg_rdata_o = '0;
         endcase
      end
   end

   feac_irq_merge #(.W(NSRC)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (lat_q),
      .ena_i   (en_q),
      .grp_i   (grp_q),
      .irq_o   (irq_o)
   );

endmodule

// File: rtl/feac_evt_irq_chk.sv
module feac_evt_irq_chk
   import feac_irq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_fifo_ovf_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic              reg_wr_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              irq_o,
   input logic [NSRC-1:0]   lat_q,
   input logic [NSRC-1:0]   en_q,
   input logic              grp_q
);

   localparam int OVF_BIT = NSRC - 1;

   logic [NSRC-1:0] wmask;
   logic [NSRC-1:0] keep;

   assign wmask = (reg_wr_i && reg_addr_i == ADDR_W'(0)) ? reg_wdata_i[NSRC-1:0] : '0;
   assign keep  = lat_q & ~wmask;

   // R5 R7
   ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fifo_ovf_i |=> lat_q[OVF_BIT]);

   // R6
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((lat_q & $past(keep)) == $past(keep)));

   // R8
   grp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_q |=> !irq_o);

   // R8
   ena_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |=> !irq_o);

   // R8
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_q && ((lat_q & en_q) != '0)) |=> irq_o);

   // R9
   rsv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata_o[DATA_W-1:NSRC] == '0);

endmodule

bind feac_evt_irq feac_evt_irq_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_fifo_ovf_i (rx_fifo_ovf_i),
   .reg_addr_i    (reg_addr_i),
   .reg_wr_i      (reg_wr_i),
   .reg_wdata_i   (reg_wdata_i),
   .reg_rdata_o   (reg_rdata_o),
   .irq_o         (irq_o),
   .lat_q         (lat_q),
   .en_q          (en_q),
   .grp_q         (grp_q)
);

// File: tb/feac_evt_irq_bench.sv
module feac_evt_irq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_idle = 1'b0, rx_cw = 1'b0, rx_idle = 1'b0;
   logic       empty = 1'b0, ovf = 1'b0;
   logic [1:0] addr = '0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   feac_evt_irq u_feac_evt_irq (
      .clk             (clk),
      .rst_n           (rst_n),
      .tx_idle_i       (tx_idle),
      .rx_cw_det_i     (rx_cw),
      .rx_idle_i       (rx_idle),
      .rx_fifo_empty_i (empty),
      .rx_fifo_ovf_i   (ovf),
      .reg_addr_i      (addr),
      .reg_wr_i        (wr),
      .reg_wdata_i     (wdata),
      .reg_rdata_o     (rdata),
      .irq_o           (irq)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic reg_read(logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   // one event per set bit of p, then inputs back to their quiet levels
   task automatic fire(logic [4:0] p);
      @(negedge clk);
      tx_idle = p[0]; rx_cw = p[1]; rx_idle = p[2]; empty = ~p[3]; ovf = p[4];
      @(negedge clk);
      tx_idle = 1'b0; rx_cw = 1'b0; rx_idle = 1'b0; empty = 1'b1; ovf = 1'b0;
   endtask

   initial begin : watchdog
      int cyc;
      cyc = 0;
      while (!done && cyc < WDOG_LIMIT) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG_LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] d;
      string tags [5];
      tags = '{"R1", "R2", "R3", "R4", "R5"};

      // reset with the FIFO reported non-empty throughout
      tick(3);
      rst_n = 1'b1;
      tick(1);
      for (int a = 0; a < 4; a++) begin
         reg_read(2'(a), d);
         check("R10 reset register", {24'd0, d}, 32'd0);
      end
      check("R10 reset irq", {31'd0, irq}, 32'd0);

      // R4: empty held low since reset never sets bit 3
      tick(3);
      reg_read(2'd0, d);
      check("R4 no arm after reset", {31'd0, d[3]}, 32'd0);
      @(negedge clk); empty = 1'b1;
      @(negedge clk); empty = 1'b0;
      @(negedge clk); empty = 1'b1;
      reg_read(2'd0, d);
      check("R4 falling empty", {31'd0, d[3]}, 32'd1);
      reg_write(2'd0, 8'h1F);

      // exhaustive sweep: flags x enables x group
      for (int p = 0; p < 32; p++) begin
         reg_write(2'd0, 8'h1F);
         fire(5'(p));
         reg_read(2'd0, d);
         for (int b = 0; b < 5; b++)
            check(tags[b], {31'd0, d[b]}, {31'd0, p[b]});
         for (int e = 0; e < 32; e++) begin
            for (int g = 0; g < 2; g++) begin
               reg_write(2'd1, 8'(e));
               reg_write(2'd2, 8'(g));
               tick(1);
               check("R8 sweep irq", {31'd0, irq},
                     {31'd0, ((p & e) != 0) && (g == 1)});
            end
         end
      end
      reg_write(2'd1, 8'h00);
      reg_write(2'd2, 8'h00);
      reg_write(2'd0, 8'h1F);

      // R1: held-high transmit idle does not set again after a clear
      @(negedge clk); tx_idle = 1'b1;
      @(negedge clk);
      reg_read(2'd0, d);
      check("R1 rise", {31'd0, d[0]}, 32'd1);
      reg_write(2'd0, 8'h01);
      tick(3);
      reg_read(2'd0, d);
      check("R1 held high stays clear", {31'd0, d[0]}, 32'd0);
      @(negedge clk); tx_idle = 1'b0;
      @(negedge clk); tx_idle = 1'b1;
      @(negedge clk); tx_idle = 1'b0;
      reg_read(2'd0, d);
      check("R1 new rise", {31'd0, d[0]}, 32'd1);

      // R2/R3: held-high receive lines, one edge each
      reg_write(2'd0, 8'h1F);
      @(negedge clk); rx_cw = 1'b1; rx_idle = 1'b1;
      @(negedge clk);
      reg_write(2'd0, 8'h06);
      tick(2);
      reg_read(2'd0, d);
      check("R2 R3 held high after clear", {24'd0, d}, 32'd0);
      @(negedge clk); rx_cw = 1'b0; rx_idle = 1'b0;

      // R6: zeros and reserved bits leave flags alone
      reg_write(2'd0, 8'h1F);
      fire(5'b10101);
      reg_write(2'd0, 8'h00);
      reg_read(2'd0, d);
      check("R6 write zero", {24'd0, d}, 32'h15);
      reg_write(2'd0, 8'hE0);
      reg_read(2'd0, d);
      check("R6 reserved write", {24'd0, d}, 32'h15);
      reg_write(2'd0, 8'h04);
      reg_read(2'd0, d);
      check("R6 single clear", {24'd0, d}, 32'h11);

      // R7: clear of bits 4 and 0 in the cycle their events arrive
      @(negedge clk);
      addr = 2'd0; wdata = 8'h11; wr = 1'b1; ovf = 1'b1; tx_idle = 1'b1;
      @(negedge clk);
      wr = 1'b0; wdata = '0; ovf = 1'b0; tx_idle = 1'b0;
      reg_read(2'd0, d);
      check("R7 set beats clear", {24'd0, d}, 32'h11);

      // R8: one-cycle latency from flag and from group enable
      reg_write(2'd1, 8'h10);
      reg_write(2'd2, 8'h01);
      reg_write(2'd0, 8'h1F);
      tick(1);
      check("R8 idle", {31'd0, irq}, 32'd0);
      @(negedge clk); ovf = 1'b1;
      @(negedge clk); ovf = 1'b0;
      check("R8 not yet", {31'd0, irq}, 32'd0);
      tick(1);
      check("R8 raised", {31'd0, irq}, 32'd1);
      reg_write(2'd2, 8'h00);
      check("R8 group off pending", {31'd0, irq}, 32'd1);
      tick(1);
      check("R8 group off", {31'd0, irq}, 32'd0);

      // R9: register widths and reserved space
      reg_write(2'd1, 8'hFF);
      reg_read(2'd1, d);
      check("R9 enable width", {24'd0, d}, 32'h1F);
      reg_write(2'd2, 8'hFF);
      reg_read(2'd2, d);
      check("R9 group width", {24'd0, d}, 32'h01);
      reg_write(2'd3, 8'hFF);
      reg_read(2'd3, d);
      check("R9 reserved address", {24'd0, d}, 32'h00);
      reg_read(2'd0, d);
      check("R9 flag upper bits", {29'd0, d[7:5]}, 32'd0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule